// File: doc/BRIEF.md
# Distributed Bus Master Arbitration Node

This block sits on each card that can take over the system bus for direct memory access. There is no central arbiter. Each card has one node, and the nodes compete over seven shared open-collector priority lines. A node raises the common bus request together with its own priority line. The main processor card then answers with a bus grant, and at that moment every node latches whether it is the highest-priority requester. The winner waits for the running bus cycle to finish, which it sees as address strobe and transfer acknowledge both high. It then drives grant acknowledge, enables its bus buffers and tells its local DMA engine to proceed.

Requests are served first come, first served. Priority decides only between requests that are pending together when the grant arrives. A node that holds the bus keeps it until its engine is done. A higher-priority request cannot take the bus away. Every bus-side output is an active-low open-collector pull: a value of 0 means the node pulls the wire low. The wired level of each line comes back on a separate input. The local side is a level request from the engine and a proceed output. The engine drops its request to mark that its last cycle is complete.

Top module: `dmaArbNode`

## Requirements
- R1: After reset, `busReqDrvN`, `grantAckDrvN` and every bit of `prioDrvN` are 1 (released), and `proceed` and `bufEn` are 0.
- R2: A request starts only at a clock edge where `reqIn` is 1 and the wired lines `busReqInN`, `busGrantN` and `grantAckInN` are all 1. From that edge the node drives `busReqDrvN` to 0, and in the same edge drives to 0 bit `MY_LEVEL-1` of `prioDrvN`.
- R3: At the first edge at which a requesting node samples `busGrantN` at 0, the node wins if and only if no priority line numbered above its own is low. Line n is bit n-1 of `prioLinesN`, and line 7 (bit 6) is the highest.
- R4: A winning node drives `grantAckDrvN` to 0 at the first edge at which it samples both `addrStrobeN` and `xferAckN` at 1, and not before.
- R5: At any edge at which `grantAckInN` is sampled at 0, a node that is requesting releases `busReqDrvN` and its priority bit together. The winner releases them at the same edge at which it asserts grant acknowledge.
- R6: A losing node keeps driving its request and priority line until it sees grant acknowledge. It then releases both, and starts no new request until all three bus lines named in R2 are high again.
- R7: While the node drives grant acknowledge and `reqIn` stays 1, it keeps driving grant acknowledge, whatever the priority, request and grant lines do.
- R8: After `reqIn` falls, the master releases `grantAckDrvN` and turns its buffers off at the first edge at which it samples `xferAckN` at 1.
- R9: `proceed` and `bufEn` are 1 exactly while this node drives `grantAckDrvN` to 0.
- R10: `busReqDrvN` and the node's own priority bit of `prioDrvN` always carry the same value. Every other bit of `prioDrvN` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | 1 | Bus wanted by the local DMA engine; dropped after its last cycle |
| proceed | output | 1 | Engine may run bus cycles |
| bufEn | output | 1 | Enable for the card's tri-state bus buffers |
| busReqInN | input | 1 | Wired level of the bus request line |
| busReqDrvN | output | 1 | This node's pull on the bus request line (0 = pull low) |
| busGrantN | input | 1 | Bus grant from the main card, active low |
| grantAckInN | input | 1 | Wired level of grant acknowledge |
| grantAckDrvN | output | 1 | This node's pull on grant acknowledge (0 = pull low) |
| addrStrobeN | input | 1 | Bus address strobe, active low |
| xferAckN | input | 1 | Bus transfer acknowledge, active low |
| prioLinesN | input | LEVELS | Wired levels of the priority lines; bit n-1 is line n |
| prioDrvN | output | LEVELS | This node's pulls on the priority lines |

## Verification
Some rules are checked by assertions on every cycle. A request may only rise while the bus is idle. Grant acknowledge may only rise after the end of a bus cycle and may only fall after the engine's request has dropped. Grant acknowledge seen on the bus always clears the node's own request. A master with a pending request stays master. The request and priority pulls always move together. The bench scenarios are what show the priority outcome itself. Losing to a higher line while still holding the request, beating a lower line, and refusing to yield to a higher line that arrives later all depend on how the lines from other cards are ordered in time. The scenarios also show the node waiting for an idle bus before it requests again.

// File: rtl/dmaArbPkg.sv
package dmaArbPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_OWN,
    ST_LOST
  } arbState_e;

  typedef struct packed {
    logic raiseReq;
    logic dropReq;
    logic latchWin;
    logic raiseAck;
    logic dropAck;
  } arbStrobe_t;
endpackage

// File: rtl/dmaArbData.sv
module dmaArbData
  import dmaArbPkg::*;
#(
  parameter int LEVELS   = 7,
  parameter int MY_LEVEL = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic [LEVELS-1:0] prioLinesN,
  output logic              winNow,
  output logic              reqDrv,
  output logic              prioDrv,
  output logic              ackDrv
);
  localparam int OWN_IDX = MY_LEVEL - 1;

  logic [LEVELS-1:0] higherMask;
  logic              wonLatched;

  // one mask bit per line numbered above this node's line
  for (genvar i = 0; i < LEVELS; i++) begin : g_mask
    assign higherMask[i] = (i > OWN_IDX);
  end

  assign winNow = !prioLinesN[OWN_IDX] && ((~prioLinesN & higherMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqDrv     <= 1'b0;
      prioDrv    <= 1'b0;
      ackDrv     <= 1'b0;
      wonLatched <= 1'b0;
    end else begin
      if (strobe.raiseReq) begin
        reqDrv  <= 1'b1;
        prioDrv <= 1'b1;
      end else if (strobe.dropReq) begin
        reqDrv  <= 1'b0;
        prioDrv <= 1'b0;
      end
      if (strobe.raiseAck)     ackDrv <= 1'b1;
      else if (strobe.dropAck) ackDrv <= 1'b0;
      if (strobe.latchWin)     wonLatched <= winNow;
      else if (strobe.dropAck) wonLatched <= 1'b0;
    end
  end

  // R3
  won_before_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrv) |-> wonLatched);
endmodule

// File: rtl/dmaArbCtrl.sv
module dmaArbCtrl
  import dmaArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqIn,
  input  logic       busReqInN,
  input  logic       busGrantN,
  input  logic       grantAckInN,
  input  logic       addrStrobeN,
  input  logic       xferAckN,
  input  logic       winNow,
  input  logic       reqDrv,
  input  logic       ackDrv,
  output arbStrobe_t strobe
);
  arbState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqIn && busReqInN && busGrantN && grantAckInN) begin
          strobe.raiseReq = 1'b1;
          nextState       = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!grantAckInN) begin
          strobe.dropReq = 1'b1;
          nextState      = ST_IDLE;
        end else if (!busGrantN) begin
          strobe.latchWin = 1'b1;
          nextState       = winNow ? ST_WAIT : ST_LOST;
        end
      end
      ST_WAIT: begin
        if (!grantAckInN) begin
          strobe.dropReq = 1'b1;
          nextState      = ST_IDLE;
        end else if (addrStrobeN && xferAckN) begin
          strobe.raiseAck = 1'b1;
          strobe.dropReq  = 1'b1;
          nextState       = ST_OWN;
        end
      end
      ST_LOST: begin
        if (!grantAckInN) begin
          strobe.dropReq = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      ST_OWN: begin
        if (!reqIn && xferAckN) begin
          strobe.dropAck = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R2
  idle_bus_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqDrv) |-> $past(reqIn && busReqInN && busGrantN && grantAckInN));
  // R4
  cycle_end_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrv) |-> $past(addrStrobeN && xferAckN));
  // R5
  ack_withdraw_chk: assert property (@(posedge clk) disable iff (!rstN)
    !grantAckInN |=> !reqDrv);
  // R7
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackDrv && reqIn) |=> ackDrv);
  // R8
  release_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackDrv) |-> $past(!reqIn && xferAckN));
endmodule

// File: rtl/dmaArbNode.sv
module dmaArbNode
  import dmaArbPkg::*;
#(
  parameter int LEVELS   = 7,
  parameter int MY_LEVEL = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIn,
  output logic              proceed,
  output logic              bufEn,
  input  logic              busReqInN,
  output logic              busReqDrvN,
  input  logic              busGrantN,
  input  logic              grantAckInN,
  output logic              grantAckDrvN,
  input  logic              addrStrobeN,
  input  logic              xferAckN,
  input  logic [LEVELS-1:0] prioLinesN,
  output logic [LEVELS-1:0] prioDrvN
);
  localparam int OWN_IDX = MY_LEVEL - 1;

  arbStrobe_t strobe;
  logic       winNow, reqDrv, prioDrv, ackDrv;

  dmaArbCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .busReqInN(busReqInN), .busGrantN(busGrantN), .grantAckInN(grantAckInN),
    .addrStrobeN(addrStrobeN), .xferAckN(xferAckN),
    .winNow(winNow), .reqDrv(reqDrv), .ackDrv(ackDrv), .strobe(strobe)
  );

  dmaArbData #(.LEVELS(LEVELS), .MY_LEVEL(MY_LEVEL)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prioLinesN(prioLinesN),
    .winNow(winNow), .reqDrv(reqDrv), .prioDrv(prioDrv), .ackDrv(ackDrv)
  );

  for (genvar i = 0; i < LEVELS; i++) begin : g_prio
    if (i == OWN_IDX) begin : g_own
      assign prioDrvN[i] = ~prioDrv;
    end else begin : g_other
      assign prioDrvN[i] = 1'b1;
    end
  end

  assign busReqDrvN   = ~reqDrv;
  assign grantAckDrvN = ~ackDrv;
  assign proceed      = ackDrv;
  assign bufEn        = ackDrv;

  // R10
  req_prio_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReqDrvN == prioDrvN[OWN_IDX]);
endmodule

// File: tb/dmaArbNode_bench.sv
`timescale 1ns/1ps
module dmaArbNode_bench;
  localparam int LEVELS = 7;
  localparam int MY_LEVEL = 4;
  localparam logic [LEVELS-1:0] OWN_PULL = 7'b1110111;
  localparam logic [LEVELS-1:0] NONE = 7'b1111111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqIn = 1'b0;
  logic busGrantN = 1'b1;
  logic addrStrobeN = 1'b1;
  logic xferAckN = 1'b1;
  logic otherReqN = 1'b1;
  logic otherAckN = 1'b1;
  logic [LEVELS-1:0] otherPrioN = NONE;
  logic proceed, bufEn, busReqDrvN, grantAckDrvN;
  logic busReqInN, grantAckInN;
  logic [LEVELS-1:0] prioLinesN, prioDrvN;
  int vecCount = 0;
  int errCount = 0;

  always #2.5 clk = ~clk;

  assign busReqInN   = busReqDrvN & otherReqN;
  assign grantAckInN = grantAckDrvN & otherAckN;
  assign prioLinesN  = prioDrvN & otherPrioN;

  dmaArbNode #(.LEVELS(LEVELS), .MY_LEVEL(MY_LEVEL)) u_dmaArbNode (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .proceed(proceed), .bufEn(bufEn),
    .busReqInN(busReqInN), .busReqDrvN(busReqDrvN), .busGrantN(busGrantN),
    .grantAckInN(grantAckInN), .grantAckDrvN(grantAckDrvN),
    .addrStrobeN(addrStrobeN), .xferAckN(xferAckN),
    .prioLinesN(prioLinesN), .prioDrvN(prioDrvN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkIdle(input string tag);
    check({tag, " req"}, busReqDrvN, 1);
    check({tag, " prio"}, prioDrvN, NONE);
    check({tag, " ack"}, grantAckDrvN, 1);
    check({tag, " proceed"}, proceed, 0);
    check({tag, " bufEn"}, bufEn, 0);
  endtask

  task automatic checkMaster(input string tag);
    check({tag, " ack"}, grantAckDrvN, 0);
    check({tag, " proceed R9"}, proceed, 1);
    check({tag, " bufEn R9"}, bufEn, 1);
    check({tag, " req R5"}, busReqDrvN, 1);
    check({tag, " prio R5"}, prioDrvN, NONE);
  endtask

  task automatic releaseBus();
    reqIn = 1'b0; xferAckN = 1'b0; busGrantN = 1'b1;
    step();
    check("R8 hold while DTAK low", grantAckDrvN, 0);
    xferAckN = 1'b1;
    step();
    checkIdle("R8 released");
  endtask

  task automatic testReset();
    step();
    checkIdle("R1 reset");
  endtask

  task automatic testSoloWin();
    addrStrobeN = 1'b0; xferAckN = 1'b0; reqIn = 1'b1;
    step();
    check("R2 req asserted", busReqDrvN, 0);
    check("R10 own prio line", prioDrvN, OWN_PULL);
    busGrantN = 1'b0;
    step();
    check("R4 no ack while cycle runs", grantAckDrvN, 1);
    check("R3 still requesting", busReqDrvN, 0);
    step();
    check("R4 no ack yet", grantAckDrvN, 1);
    addrStrobeN = 1'b1; xferAckN = 1'b1;
    step();
    checkMaster("R4 take bus");
    releaseBus();
  endtask

  task automatic testBlockedStart();
    otherReqN = 1'b0; reqIn = 1'b1;
    step(); step();
    check("R2 blocked by BR", busReqDrvN, 1);
    otherReqN = 1'b1; busGrantN = 1'b0;
    step();
    check("R2 blocked by BG", busReqDrvN, 1);
    busGrantN = 1'b1; otherAckN = 1'b0;
    step();
    check("R2 blocked by GA", busReqDrvN, 1);
    otherAckN = 1'b1; reqIn = 1'b0;
    step();
    checkIdle("R2 no request left");
  endtask

  task automatic testLoseHigher();
    reqIn = 1'b1;
    step();
    check("R2 start", busReqDrvN, 0);
    otherPrioN = 7'b1011111; otherReqN = 1'b0; busGrantN = 1'b0;
    step();
    check("R6 loser keeps req", busReqDrvN, 0);
    check("R3 loser no ack", grantAckDrvN, 1);
    step();
    check("R6 loser keeps prio", prioDrvN, OWN_PULL);
    otherAckN = 1'b0; otherReqN = 1'b1; otherPrioN = NONE; busGrantN = 1'b1;
    step();
    check("R5 withdraw on GA", busReqDrvN, 1);
    check("R5 prio withdrawn", prioDrvN, NONE);
    step();
    check("R6 wait for idle", busReqDrvN, 1);
    otherAckN = 1'b1;
    step();
    check("R6 re-request", busReqDrvN, 0);
    busGrantN = 1'b0;
    step();
    step();
    checkMaster("R3 later win");
    releaseBus();
  endtask

  task automatic testBeatLowerAndHold();
    addrStrobeN = 1'b0; xferAckN = 1'b0; reqIn = 1'b1;
    step();
    otherPrioN = 7'b1111101; otherReqN = 1'b0; busGrantN = 1'b0;
    step();
    check("R3 beat lower, no ack yet", grantAckDrvN, 1);
    addrStrobeN = 1'b1;
    step();
    check("R4 DTAK still low", grantAckDrvN, 1);
    xferAckN = 1'b1;
    step();
    checkMaster("R3 winner over line 2");
    otherPrioN = 7'b0111111; otherReqN = 1'b0; busGrantN = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R7 no preemption", grantAckDrvN, 0);
    end
    otherPrioN = NONE; otherReqN = 1'b1;
    releaseBus();
  endtask

  initial begin
    #(5.0 * 20000);
    errCount++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSoloWin();
    testBlockedStart();
    testLoseHigher();
    testBeatLowerAndHold();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule